// File: doc/BRIEF.md
# Software Interrupt Priority Gate

This block decides whether a pending software interrupt may be delivered to the core, and at which level. It holds four pieces of state: a 16-bit pending mask, a processor interrupt level, an interrupt-enable flag and a hypervisor state word that contains a privilege flag. The core changes this state through one write port, which carries a register select, a data word and a write strobe.

The current request level is the index of the highest pending bit. A request goes to the core only when the privilege flag is clear, the enable flag is set and the level is strictly above the processor interrupt level. In every other case the request stays pending and is not lost. The block also sends the core a one-cycle re-evaluate strobe after the writes that can newly allow a delivery.

Top module: `swint_gate`

## Requirements
- R1: The request level is the index of the highest set bit among pending bits 15 down to 1. Bit 0 never counts toward the level. A level of 0 means no request.
- R2: While hypervisor state bit 2 (privilege) is 1, `take_irq` stays 0. The pending bits are kept.
- R3: When the request level is less than or equal to the processor interrupt level, `take_irq` stays 0.
- R4: When the enable flag (state-register data bit 1) is 0, `take_irq` stays 0.
- R5: When privilege is clear, enable is set and level > interrupt level, `take_irq` is 1 in the cycle after the state that allows it is registered. `take_level` then equals the request level. Both hold for as long as those conditions hold. When `take_irq` is 0, `take_level` is 0.
- R6: Every write with select 0 loads the pending mask from the data word. `recheck` is then 1 for the following cycle.
- R7: A write with select 2 raises `recheck` in the following cycle only if it changes the enable flag from 0 to 1.
- R8: A write with select 3 loads the interrupt level from data bits 3:0. It raises `recheck` in the following cycle only if the new value is below the old one.
- R9: Every write with select 4 stores the data word into the hypervisor state with bit 11 forced to 1.
- R10: A write with select 1 clears each pending bit whose data bit is 1, effective from the next cycle, and raises `recheck` in the following cycle.
- R11: After reset the pending mask, interrupt level, enable, `take_irq`, `take_level` and `recheck` are 0, and `hyp_state` is 0x0800.
- R12: Writes with select codes 5 to 7 change no state and raise no `recheck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Register select (0 pending load, 1 pending clear, 2 state, 3 interrupt level, 4 hypervisor state) |
| wr_data | input | 16 | Write data |
| pend_bits | output | 16 | Current pending mask |
| hyp_state | output | 16 | Current hypervisor state word |
| take_irq | output | 1 | Deliver-interrupt indication |
| take_level | output | 4 | Level being delivered |
| recheck | output | 1 | One-cycle re-evaluate strobe |

## Verification
A write can land in the same cycle as an active delivery. The re-evaluate strobe from a pending-mask write or a clear then overlaps a `take_level` that still shows the old level, and the new level appears one cycle later. The bench provokes this by rewriting the mask and by clearing bits while a delivery is held. It samples both outputs at the strobe cycle, where it expects the strobe with the old level, and again one cycle on, where it expects the new level. Privilege and interrupt-level writes that arrive during a held delivery are judged the same way: the delivery must drop exactly one cycle after the write, and no strobe may appear.

// File: rtl/swint_pkg.sv
`timescale 1ns/1ps
// Package: shared select encoding for the software interrupt gate.
// Assumes a 3-bit register select on the write port.
package swint_pkg;

    typedef enum logic [2:0] {
        SEL_PEND   = 3'd0,
        SEL_CLR    = 3'd1,
        SEL_STATE  = 3'd2,
        SEL_PIL    = 3'd3,
        SEL_HSTATE = 3'd4
    } reg_sel_e;

    localparam int SEL_W = 3;

endpackage

// File: rtl/swint_prio.sv
`timescale 1ns/1ps
// swint_prio: finds the index of the highest set pending bit.
// Bit 0 is excluded, so an output of zero means nothing is pending.
// Purely combinational. Assumes LVL_W can hold PEND_W-1.
module swint_prio #(
    parameter int PEND_W = 16,
    parameter int LVL_W  = $clog2(PEND_W)
) (
    input  logic [PEND_W-1:0] pend,
    output logic [LVL_W-1:0]  lvl
);

    logic [PEND_W-1:0] hit;
    logic [LVL_W-1:0]  term [PEND_W];

    // One-hot winner per bit position, then its index term
    for (genvar i = 0; i < PEND_W; i++) begin : g_bit
        if (i == 0) begin : g_ignore
            assign hit[i] = 1'b0 & pend[i];
        end else if (i == PEND_W - 1) begin : g_top
            assign hit[i] = pend[i];
        end else begin : g_mid
            assign hit[i] = pend[i] & ~(|pend[PEND_W-1:i+1]);
        end
        assign term[i] = hit[i] ? LVL_W'(i) : '0;
    end

    // OR of all index terms (at most one is nonzero)
    always_comb begin
        lvl = '0;
        for (int k = 0; k < PEND_W; k++) begin
            lvl = lvl | term[k];
        end
    end

endmodule

// File: rtl/swint_regs.sv
`timescale 1ns/1ps
// swint_regs: the write-port register set (pending mask, interrupt level,
// enable flag, hypervisor state) and the registered re-evaluate strobe.
// Assumes one write per cycle. Unknown selects are ignored.
module swint_regs
    import swint_pkg::*;
#(
    parameter int PEND_W    = 16,
    parameter int PIL_W     = 4,
    parameter int IE_BIT    = 1,
    parameter int HPRIV_BIT = 2,
    parameter int FIXED_BIT = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [PEND_W-1:0] wdata,
    output logic [PEND_W-1:0] pend_q,
    output logic [PIL_W-1:0]  pil_q,
    output logic              ie_q,
    output logic [PEND_W-1:0] hstate_q,
    output logic              hpriv,
    output logic              recheck_q
);

    localparam logic [PEND_W-1:0] FIXED_MASK = {{(PEND_W-1){1'b0}}, 1'b1} << FIXED_BIT;

    logic rc_d;

    // Decide which writes call for a re-evaluation
    always_comb begin
        rc_d = 1'b0;
        if (we) begin
            case (sel)
                SEL_PEND:  rc_d = 1'b1;
                SEL_CLR:   rc_d = 1'b1;
                SEL_STATE: rc_d = wdata[IE_BIT] & ~ie_q;
                SEL_PIL:   rc_d = (wdata[PIL_W-1:0] < pil_q);
                default:   rc_d = 1'b0;
            endcase
        end
    end

    // Register updates from the write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            pil_q     <= '0;
            ie_q      <= 1'b0;
            hstate_q  <= FIXED_MASK;
            recheck_q <= 1'b0;
        end else begin
            recheck_q <= rc_d;
            if (we) begin
                case (sel)
                    SEL_PEND:   pend_q   <= wdata;
                    SEL_CLR:    pend_q   <= pend_q & ~wdata;
                    SEL_STATE:  ie_q     <= wdata[IE_BIT];
                    SEL_PIL:    pil_q    <= wdata[PIL_W-1:0];
                    SEL_HSTATE: hstate_q <= wdata | FIXED_MASK;
                    default:    ;
                endcase
            end
        end
    end

    assign hpriv = hstate_q[HPRIV_BIT];

endmodule

// File: rtl/swint_decide.sv
`timescale 1ns/1ps
// swint_decide: delivery gate. Takes the interrupt when privilege is
// clear, enable is set and level > interrupt level. The result is
// registered, so delivery follows the state by one cycle.
module swint_decide #(
    parameter int LVL_W = 4,
    parameter int PIL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] lvl,
    input  logic [PIL_W-1:0] pil,
    input  logic             ie,
    input  logic             hpriv,
    output logic             take_q,
    output logic [LVL_W-1:0] take_lvl_q
);

    localparam int CMP_W = (LVL_W > PIL_W) ? LVL_W : PIL_W;

    logic [CMP_W-1:0] lvl_x;
    logic [CMP_W-1:0] pil_x;
    logic             go;

    // Widen both operands and form the joint gate
    always_comb begin
        lvl_x = CMP_W'(lvl);
        pil_x = CMP_W'(pil);
        go    = ~hpriv & ie & (lvl_x > pil_x);
    end

    // Register the delivery and its level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_q     <= 1'b0;
            take_lvl_q <= '0;
        end else begin
            take_q     <= go;
            take_lvl_q <= go ? lvl : '0;
        end
    end

endmodule

// File: rtl/swint_gate.sv
`timescale 1ns/1ps
// swint_gate: top of the software interrupt priority gate. Links the
// register set, the priority encoder and the delivery gate.
// Assumes a synchronous active-low reset and one write per cycle.
module swint_gate
    import swint_pkg::*;
#(
    parameter int PEND_W    = 16,
    parameter int PIL_W     = 4,
    parameter int IE_BIT    = 1,
    parameter int HPRIV_BIT = 2,
    parameter int FIXED_BIT = 11,
    parameter int LVL_W     = $clog2(PEND_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [PEND_W-1:0] wr_data,
    output logic [PEND_W-1:0] pend_bits,
    output logic [PEND_W-1:0] hyp_state,
    output logic              take_irq,
    output logic [LVL_W-1:0]  take_level,
    output logic              recheck
);

    logic [PIL_W-1:0] pil;
    logic             ie;
    logic             hpriv;
    logic [LVL_W-1:0] cur_lvl;

    swint_regs #(
        .PEND_W(PEND_W), .PIL_W(PIL_W), .IE_BIT(IE_BIT),
        .HPRIV_BIT(HPRIV_BIT), .FIXED_BIT(FIXED_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .sel(wr_sel), .wdata(wr_data),
        .pend_q(pend_bits), .pil_q(pil), .ie_q(ie), .hstate_q(hyp_state),
        .hpriv(hpriv), .recheck_q(recheck)
    );

    swint_prio #(.PEND_W(PEND_W), .LVL_W(LVL_W)) u_prio (
        .pend(pend_bits), .lvl(cur_lvl)
    );

    swint_decide #(.LVL_W(LVL_W), .PIL_W(PIL_W)) u_decide (
        .clk(clk), .rst_n(rst_n), .lvl(cur_lvl), .pil(pil), .ie(ie),
        .hpriv(hpriv), .take_q(take_irq), .take_lvl_q(take_level)
    );

endmodule

// File: rtl/swint_gate_chk.sv
`timescale 1ns/1ps
// swint_gate_chk: temporal checks on the gate, bound to swint_gate.
module swint_gate_chk
    import swint_pkg::*;
#(
    parameter int PEND_W    = 16,
    parameter int PIL_W     = 4,
    parameter int FIXED_BIT = 11,
    parameter int LVL_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_sel,
    input logic [PEND_W-1:0] wr_data,
    input logic [PEND_W-1:0] pend_bits,
    input logic [PEND_W-1:0] hyp_state,
    input logic              take_irq,
    input logic [LVL_W-1:0]  take_level,
    input logic              recheck,
    input logic [LVL_W-1:0]  lvl,
    input logic [PIL_W-1:0]  pil,
    input logic              ie,
    input logic              hpriv
);

    AST_HPRIV_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) take_irq |-> !$past(hpriv)); // R2
    AST_PIL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) take_irq |-> (32'($past(lvl)) > 32'($past(pil)))); // R3
    AST_IE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) take_irq |-> $past(ie)); // R4
    AST_TAKE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) take_irq |-> (take_level == $past(lvl))); // R5
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) !take_irq |-> (take_level == '0)); // R5
    AST_PEND_RECHECK: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_sel == SEL_PEND) |=> recheck); // R6
    AST_IE_SET_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_sel == SEL_STATE && ie) |=> !recheck); // R7
    AST_PIL_RAISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_sel == SEL_PIL && wr_data[PIL_W-1:0] >= pil) |=> !recheck); // R8
    AST_FIXED_BIT: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_sel == SEL_HSTATE) |=> hyp_state[FIXED_BIT]); // R9
    AST_CLR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_sel == SEL_CLR) |=> ((pend_bits & $past(wr_data)) == '0)); // R10
    AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_sel > 3'd4) |=> (!recheck && $stable(pend_bits) && $stable(hyp_state))); // R12

endmodule

bind swint_gate swint_gate_chk #(
    .PEND_W(PEND_W), .PIL_W(PIL_W), .FIXED_BIT(FIXED_BIT), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pend_bits(pend_bits), .hyp_state(hyp_state), .take_irq(take_irq),
    .take_level(take_level), .recheck(recheck), .lvl(cur_lvl), .pil(pil),
    .ie(ie), .hpriv(hpriv)
);

// File: tb/sim_swint_gate.sv
`timescale 1ns/1ps
module sim_swint_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] pend_bits;
    logic [15:0] hyp_state;
    logic        take_irq;
    logic [3:0]  take_level;
    logic        recheck;

    int n_chk = 0;
    int n_bad = 0;
    logic last_rc;

    always #2.5 clk = ~clk;

    swint_gate u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pend_bits(pend_bits), .hyp_state(hyp_state),
        .take_irq(take_irq), .take_level(take_level), .recheck(recheck)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One write; samples recheck in the cycle after the write edge
    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(posedge clk); #1;
        last_rc = recheck;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        chk("R11 take", 32'(take_irq), 0);
        chk("R11 level", 32'(take_level), 0);
        chk("R11 recheck", 32'(recheck), 0);
        chk("R11 pend", 32'(pend_bits), 0);
        chk("R11 hyp", 32'(hyp_state), 32'h0800);
    endtask

    task automatic t_level();
        wr(3'd2, 16'h0002);
        chk("R7 rise", 32'(last_rc), 1);
        wr(3'd0, 16'h0001);
        chk("R6 recheck", 32'(last_rc), 1);
        step();
        chk("R1 bit0 take", 32'(take_irq), 0);
        chk("R1 bit0 level", 32'(take_level), 0);
        wr(3'd0, 16'h0010);
        chk("R5 not yet", 32'(take_irq), 0);
        step();
        chk("R5 take", 32'(take_irq), 1);
        chk("R1 level4", 32'(take_level), 4);
        wr(3'd0, 16'h8001);
        step();
        chk("R1 level15", 32'(take_level), 15);
        wr(3'd0, 16'h0006);
        chk("R6 overlap rc", 32'(last_rc), 1);
        chk("R5 old level", 32'(take_level), 15);
        step();
        chk("R1 level2", 32'(take_level), 2);
        step();
        chk("R5 held", 32'(take_irq), 1);
    endtask

    task automatic t_pil();
        wr(3'd0, 16'h0020);
        wr(3'd3, 16'h0005);
        chk("R8 raise quiet", 32'(last_rc), 0);
        step();
        chk("R3 equal blocks", 32'(take_irq), 0);
        wr(3'd3, 16'h0005);
        chk("R8 same quiet", 32'(last_rc), 0);
        wr(3'd3, 16'h0004);
        chk("R8 lower rc", 32'(last_rc), 1);
        step();
        chk("R3 above", 32'(take_irq), 1);
        chk("R3 level", 32'(take_level), 5);
        wr(3'd3, 16'h0009);
        chk("R8 raise2 quiet", 32'(last_rc), 0);
        step();
        chk("R3 below blocks", 32'(take_irq), 0);
        wr(3'd3, 16'h0000);
        step();
    endtask

    task automatic t_ie();
        wr(3'd2, 16'h0000);
        chk("R7 clear quiet", 32'(last_rc), 0);
        step();
        chk("R4 blocks", 32'(take_irq), 0);
        chk("R4 pending kept", 32'(pend_bits), 32'h0020);
        wr(3'd2, 16'h0000);
        chk("R7 stay0 quiet", 32'(last_rc), 0);
        wr(3'd2, 16'h0002);
        chk("R7 rise rc", 32'(last_rc), 1);
        step();
        chk("R4 enabled", 32'(take_irq), 1);
        wr(3'd2, 16'h0002);
        chk("R7 stay1 quiet", 32'(last_rc), 0);
    endtask

    task automatic t_hpriv();
        wr(3'd4, 16'h0004);
        chk("R9 forced", 32'(hyp_state), 32'h0804);
        step();
        chk("R2 blocks", 32'(take_irq), 0);
        chk("R2 pending kept", 32'(pend_bits), 32'h0020);
        wr(3'd4, 16'h0000);
        chk("R9 forced2", 32'(hyp_state), 32'h0800);
        step();
        chk("R2 released", 32'(take_irq), 1);
    endtask

    task automatic t_clr();
        wr(3'd0, 16'h0030);
        wr(3'd1, 16'h0020);
        chk("R10 rc", 32'(last_rc), 1);
        chk("R10 w1c", 32'(pend_bits), 32'h0010);
        chk("R10 old level", 32'(take_level), 5);
        step();
        chk("R10 new level", 32'(take_level), 4);
        wr(3'd1, 16'hFFFF);
        chk("R10 all", 32'(pend_bits), 0);
        step();
        chk("R10 no take", 32'(take_irq), 0);
    endtask

    task automatic t_unused();
        wr(3'd0, 16'h0100);
        wr(3'd5, 16'hFFFF);
        chk("R12 rc5", 32'(last_rc), 0);
        chk("R12 pend5", 32'(pend_bits), 32'h0100);
        wr(3'd7, 16'h0000);
        chk("R12 rc7", 32'(last_rc), 0);
        chk("R12 pend7", 32'(pend_bits), 32'h0100);
        chk("R12 hyp", 32'(hyp_state), 32'h0800);
        step();
        chk("R12 take", 32'(take_irq), 1);
        chk("R12 level", 32'(take_level), 8);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_level();
        t_pil();
        t_ie();
        t_hpriv();
        t_clr();
        t_unused();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule